// File: doc/BRIEF.md
# Software write-protection flag controller

This block sits beside the two-wire bus slave of a 256-byte serial memory and owns the two software protection flags. One flag is permanent and can only ever go from 0 to 1. The other is reversible and can be set and cleared. The bus controller passes in every received device-address byte and reports each completed byte, each start condition and each stop condition. The block recognises the device addresses reserved for protection commands, which all have the upper nibble 0110. For each of them it returns an acknowledge decision. It also tracks the dummy-byte sequence of set and clear commands and asks for a write cycle when the sequence ends properly.

Permanent commands are selected by matching the device-address select bits against the strap pins. Reversible commands are only recognised while the A0 pin sits at high voltage, which arrives here as a digital qualifier. The flags model non-volatile cells. They start at 0 at power-up and are not touched by the functional reset. The block drives a status line, used by the array write path, that marks the lower half of the array (00h-7Fh) as read-only. The array-wide lock from the WP pin is handled outside this block.

Top module: `wp_flag_ctrl`

## Requirements
- R1: `ack_valid` pulses for exactly one cycle, one clock after an `addr_valid` cycle whose `addr_byte[7:4]` is 4'b0110. For any other upper nibble it stays low, and `ack_out` is high only together with `ack_valid`.
- R2: While `a0_hv` is low, a reserved address is a permanent command only if `addr_byte[3:1]` equals `strap`. With `addr_byte[0]`=0 it is a set; with `addr_byte[0]`=1 it is a status read. If the select bits do not match, the address is not acknowledged.
- R3: While `a0_hv` is high, select code 3'b001 means reversible set (bit 0 = 0) or reversible status read (bit 0 = 1). Select code 3'b011 means reversible clear (bit 0 = 0) or permanent status read (bit 0 = 1). Any other select code is not acknowledged.
- R4: Once the permanent flag is 1, no reserved address is acknowledged, no write cycle is requested, and the flag never returns to 0. While it is 0, set and clear commands are acknowledged.
- R5: A reversible status read is acknowledged only if the reversible flag is 0. A permanent status read is acknowledged only if the permanent flag is 0. Neither read depends on `wp_in`, requests a write cycle or changes a flag.
- R6: After an acknowledged set or clear command, two completed dummy bytes followed by a stop make `wr_req` pulse for one cycle, one clock after the stop cycle. The flag takes its new value one clock after that. This happens only if `wp_in` was low both in the address cycle and in the stop cycle. Otherwise the address is still acknowledged, but no cycle runs and no flag changes.
- R7: A start or a stop that arrives before both dummy bytes have completed cancels the set or clear command: no write cycle and no flag change.
- R8: `prot_lower` is the OR of the two flags. Both flags are 0 at power-up, and asserting `rst_n` leaves them unchanged.
- R9: During and right after reset, `ack_valid`, `ack_out` and `wr_req` are low.
- R10: Bytes that complete after the two dummy bytes and before the stop are ignored; the stop still commits the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low functional reset; does not touch the flags |
| addr_valid | input | 1 | One-cycle pulse: a device-address byte was received |
| addr_byte | input | 8 | Received device-address byte; bit 0 is the read/write bit |
| byte_done | input | 1 | One-cycle pulse: a byte after the device address completed |
| start_evt | input | 1 | One-cycle pulse: start condition seen on the bus |
| stop_evt | input | 1 | One-cycle pulse: stop condition seen on the bus |
| strap | input | 3 | Logic levels of the three address strap pins, bit 2 down to bit 0 |
| a0_hv | input | 1 | High while A0 is driven to the high-voltage level |
| wp_in | input | 1 | Write-protect pin level |
| ack_valid | output | 1 | One-cycle pulse: an acknowledge decision for a reserved address is ready |
| ack_out | output | 1 | 1 = acknowledge, 0 = no acknowledge; meaningful with `ack_valid` |
| wr_req | output | 1 | One-cycle pulse: start an internal write cycle for a flag |
| prot_lower | output | 1 | Lower half of the array is read-only |

## Verification
A wrong flag inside this block is not visible on `prot_lower` alone. It shows up at the next status read, which returns the opposite acknowledge one clock after the address, so the bench follows every flag change with reads of both flags. A sequencer that is stuck or counts dummy bytes wrongly shows up one clock after the closing stop: `wr_req` is missing or spurious, and one clock later `prot_lower` and the following status reads disagree with the expected flags. Random command mixes with random WP levels, byte counts and endings check the acknowledge table against a bench model at every address.

// File: rtl/wpf_pkg.sv
package wpf_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_SET_PERM,
        CMD_RD_PERM,
        CMD_SET_REV,
        CMD_CLR_REV,
        CMD_RD_REV
    } wpf_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DUMMY,
        ST_STOPWAIT
    } wpf_state_e;

    localparam logic [3:0] PROT_PREFIX = 4'b0110;
    localparam logic [2:0] REV_SET_SEL = 3'b001;
    localparam logic [2:0] REV_CLR_SEL = 3'b011;

    function automatic logic is_update(input wpf_cmd_e c);
        return (c == CMD_SET_PERM) || (c == CMD_SET_REV) || (c == CMD_CLR_REV);
    endfunction

endpackage

// File: rtl/wpf_addr_decode.sv
module wpf_addr_decode
    import wpf_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic [SEL_W-1:0]  strap,
    input  logic              a0_hv,
    output logic              in_space,
    output wpf_cmd_e          cmd
);
    localparam int PFX_LO = SEL_W + 1;

    logic             rd_bit;
    logic [SEL_W-1:0] sel;

    always_comb begin
        rd_bit   = addr_byte[0];
        sel      = addr_byte[SEL_W:1];
        in_space = (addr_byte[BYTE_W-1:PFX_LO] == PROT_PREFIX);
        cmd      = CMD_NONE;
        if (in_space) begin
            if (a0_hv) begin
                // high voltage on A0 selects the reversible command set
                if (sel == REV_SET_SEL) begin
                    cmd = rd_bit ? CMD_RD_REV : CMD_SET_REV;
                end else if (sel == REV_CLR_SEL) begin
                    cmd = rd_bit ? CMD_RD_PERM : CMD_CLR_REV;
                end
            end else if (sel == strap) begin
                cmd = rd_bit ? CMD_RD_PERM : CMD_SET_PERM;
            end
        end
    end
endmodule

// File: rtl/wpf_nv_flags.sv
module wpf_nv_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_perm,
    input  logic set_rev,
    input  logic clr_rev,
    output logic perm_flag,
    output logic rev_flag
);
    // Stand-ins for non-volatile cells: power-up value only, no functional reset.
    logic perm_q = 1'b0;
    logic rev_q  = 1'b0;
    logic perm_d;
    logic rev_d;

    always_comb begin
        perm_d = perm_q | set_perm;
        rev_d  = rev_q;
        if (set_rev) begin
            rev_d = 1'b1;
        end else if (clr_rev) begin
            rev_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        perm_q <= perm_d;
        rev_q  <= rev_d;
    end

    assign perm_flag = perm_q;
    assign rev_flag  = rev_q;

    assert_perm_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(perm_q))
        else $error("permanent flag returned to 0");
endmodule

// File: rtl/wpf_cmd_seq.sv
module wpf_cmd_seq
    import wpf_pkg::*;
#(
    parameter int DUMMY_BYTES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     addr_valid,
    input  logic     in_space,
    input  wpf_cmd_e cmd,
    input  logic     byte_done,
    input  logic     start_evt,
    input  logic     stop_evt,
    input  logic     wp_in,
    input  logic     perm_flag,
    input  logic     rev_flag,
    output logic     ack_valid,
    output logic     ack_out,
    output logic     wr_req,
    output logic     set_perm,
    output logic     set_rev,
    output logic     clr_rev
);
    localparam int CNT_W = $clog2(DUMMY_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DUMMY_BYTES - 1);

    typedef struct packed {
        wpf_state_e       st;
        wpf_cmd_e         cmd;
        logic [CNT_W-1:0] cnt;
        logic             wp_ok;
        logic             ack_valid;
        logic             ack;
        logic             wr_req;
        logic             set_perm;
        logic             set_rev;
        logic             clr_rev;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;
    logic grant;

    always_comb begin
        seq_d           = seq_q;
        seq_d.ack_valid = 1'b0;
        seq_d.ack       = 1'b0;
        seq_d.wr_req    = 1'b0;
        seq_d.set_perm  = 1'b0;
        seq_d.set_rev   = 1'b0;
        seq_d.clr_rev   = 1'b0;

        grant = in_space && !perm_flag && (cmd != CMD_NONE)
                && !((cmd == CMD_RD_REV) && rev_flag);

        case (seq_q.st)
            ST_DUMMY: begin
                if (start_evt || stop_evt) begin
                    seq_d.st = ST_IDLE;
                end else if (byte_done) begin
                    if (seq_q.cnt == LAST_CNT) begin
                        seq_d.st = ST_STOPWAIT;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            ST_STOPWAIT: begin
                if (start_evt) begin
                    seq_d.st = ST_IDLE;
                end else if (stop_evt) begin
                    seq_d.st = ST_IDLE;
                    if (seq_q.wp_ok && !wp_in) begin
                        seq_d.wr_req   = 1'b1;
                        seq_d.set_perm = (seq_q.cmd == CMD_SET_PERM);
                        seq_d.set_rev  = (seq_q.cmd == CMD_SET_REV);
                        seq_d.clr_rev  = (seq_q.cmd == CMD_CLR_REV);
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase

        if (addr_valid) begin
            seq_d.ack_valid = in_space;
            seq_d.ack       = grant;
            seq_d.cmd       = cmd;
            seq_d.cnt       = '0;
            seq_d.wp_ok     = !wp_in;
            seq_d.st        = (grant && is_update(cmd)) ? ST_DUMMY : ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ack_valid = seq_q.ack_valid;
    assign ack_out   = seq_q.ack;
    assign wr_req    = seq_q.wr_req;
    assign set_perm  = seq_q.set_perm;
    assign set_rev   = seq_q.set_rev;
    assign clr_rev   = seq_q.clr_rev;

    assert_ack_follows_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(addr_valid))
        else $error("decision without an address byte");

    assert_ack_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_out |-> ack_valid)
        else $error("acknowledge outside a decision slot");

    assert_wr_wp_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ($past(stop_evt) && !$past(wp_in)))
        else $error("write cycle without stop or with WP high");
endmodule

// File: rtl/wp_flag_ctrl.sv
module wp_flag_ctrl
    import wpf_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SEL_W       = 3,
    parameter int DUMMY_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid,
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic              byte_done,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [SEL_W-1:0]  strap,
    input  logic              a0_hv,
    input  logic              wp_in,
    output logic              ack_valid,
    output logic              ack_out,
    output logic              wr_req,
    output logic              prot_lower
);
    logic     in_space;
    wpf_cmd_e cmd;
    logic     perm_flag;
    logic     rev_flag;
    logic     set_perm;
    logic     set_rev;
    logic     clr_rev;

    wpf_addr_decode #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_dec (
        .addr_byte (addr_byte),
        .strap     (strap),
        .a0_hv     (a0_hv),
        .in_space  (in_space),
        .cmd       (cmd)
    );

    wpf_cmd_seq #(.DUMMY_BYTES(DUMMY_BYTES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_valid (addr_valid),
        .in_space   (in_space),
        .cmd        (cmd),
        .byte_done  (byte_done),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .wp_in      (wp_in),
        .perm_flag  (perm_flag),
        .rev_flag   (rev_flag),
        .ack_valid  (ack_valid),
        .ack_out    (ack_out),
        .wr_req     (wr_req),
        .set_perm   (set_perm),
        .set_rev    (set_rev),
        .clr_rev    (clr_rev)
    );

    wpf_nv_flags u_nv (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_perm  (set_perm),
        .set_rev   (set_rev),
        .clr_rev   (clr_rev),
        .perm_flag (perm_flag),
        .rev_flag  (rev_flag)
    );

    assign prot_lower = perm_flag | rev_flag;

    assert_perm_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && $past(perm_flag)) |-> !ack_out)
        else $error("reserved address acknowledged after permanent lock");

    assert_rev_change_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rev_flag) |-> $past(wr_req))
        else $error("reversible flag moved outside a write cycle");
endmodule

// File: tb/wp_flag_ctrl_test.sv
module wp_flag_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_valid = 1'b0;
    logic [7:0] addr_byte = 8'h00;
    logic       byte_done = 1'b0;
    logic       start_evt = 1'b0;
    logic       stop_evt = 1'b0;
    logic [2:0] strap = 3'b000;
    logic       a0_hv = 1'b0;
    logic       wp_in = 1'b0;
    logic       ack_valid;
    logic       ack_out;
    logic       wr_req;
    logic       prot_lower;

    int checks = 0;
    int errors = 0;
    bit m_perm = 1'b0;
    bit m_rev = 1'b0;

    always #10 clk = ~clk;

    wp_flag_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_valid (addr_valid),
        .addr_byte  (addr_byte),
        .byte_done  (byte_done),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .strap      (strap),
        .a0_hv      (a0_hv),
        .wp_in      (wp_in),
        .ack_valid  (ack_valid),
        .ack_out    (ack_out),
        .wr_req     (wr_req),
        .prot_lower (prot_lower)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // 0 none, 1 set perm, 2 read perm, 3 set rev, 4 clear rev, 5 read rev
    function automatic int classify(input logic [7:0] a, input logic [2:0] s, input logic hv);
        if (a[7:4] != 4'b0110) return 0;
        if (hv) begin
            if (a[3:1] == 3'b001) return a[0] ? 5 : 3;
            if (a[3:1] == 3'b011) return a[0] ? 2 : 4;
            return 0;
        end
        if (a[3:1] == s) return a[0] ? 2 : 1;
        return 0;
    endfunction

    function automatic bit exp_ack(input int k);
        if (k == 0 || m_perm) return 1'b0;
        if (k == 5 && m_rev) return 1'b0;
        return 1'b1;
    endfunction

    task automatic do_cmd(input logic [7:0] a, input int nb, input bit by_stop,
                          input bit wpa, input bit wps, input string req);
        int  k;
        bit  ea;
        bit  armed;
        bit  ew;
        k = classify(a, strap, a0_hv);
        ea = exp_ack(k);
        armed = ea && (k == 1 || k == 3 || k == 4);
        @(negedge clk);
        wp_in = wpa;
        addr_byte = a;
        addr_valid = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0;
        check(ack_valid == (a[7:4] == 4'b0110), {req, " R1 ack_valid"}, ack_valid, a[7:4] == 4'b0110);
        check(ack_out == ea, {req, " ack_out"}, ack_out, ea);
        for (int i = 0; i < nb; i++) begin
            byte_done = 1'b1;
            @(negedge clk);
            byte_done = 1'b0;
            @(negedge clk);
        end
        wp_in = wps;
        if (by_stop) stop_evt = 1'b1;
        else start_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
        start_evt = 1'b0;
        ew = armed && (nb >= 2) && by_stop && !wpa && !wps;
        check(wr_req == ew, {req, " R6 wr_req"}, wr_req, ew);
        if (ew) begin
            if (k == 1) m_perm = 1'b1;
            if (k == 3) m_rev = 1'b1;
            if (k == 4) m_rev = 1'b0;
        end
        @(negedge clk);
        check(wr_req == 1'b0, {req, " R6 wr_req one cycle"}, wr_req, 0);
        check(prot_lower == (m_perm | m_rev), {req, " R8 prot_lower"}, prot_lower, m_perm | m_rev);
    endtask

    // observe both flags through status reads
    task automatic read_flags(input string req);
        logic [2:0] s_sav;
        logic       hv_sav;
        s_sav = strap;
        hv_sav = a0_hv;
        a0_hv = 1'b1;
        do_cmd(8'h63, 0, 1'b1, 1'b0, 1'b0, {req, " R5 rd rev"});
        do_cmd(8'h67, 0, 1'b1, 1'b1, 1'b1, {req, " R5 rd perm"});
        a0_hv = hv_sav;
        strap = s_sav;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(ack_valid == 1'b0 && ack_out == 1'b0 && wr_req == 1'b0, "R9 reset outputs", {ack_valid, ack_out, wr_req}, 0);
        check(prot_lower == 1'b0, "R8 power-up flags", prot_lower, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ack_valid == 1'b0 && wr_req == 1'b0, "R9 after reset", {ack_valid, wr_req}, 0);

        strap = 3'b101;
        a0_hv = 1'b0;
        do_cmd(8'hA0, 2, 1'b1, 1'b0, 1'b0, "R1 normal address");
        do_cmd(8'h6B, 0, 1'b1, 1'b1, 1'b1, "R2 R5 read perm match");
        do_cmd(8'h63, 0, 1'b1, 1'b0, 1'b0, "R2 strap mismatch");
        do_cmd(8'h6A, 2, 1'b1, 1'b1, 1'b1, "R2 R6 set perm WP high");
        a0_hv = 1'b1;
        do_cmd(8'h63, 0, 1'b1, 1'b0, 1'b0, "R3 read rev");
        do_cmd(8'h6A, 2, 1'b1, 1'b0, 1'b0, "R3 bad select with hv");
        do_cmd(8'h62, 2, 1'b1, 1'b1, 1'b1, "R6 set rev WP high");
        do_cmd(8'h62, 2, 1'b1, 1'b0, 1'b1, "R6 set rev WP rises at stop");
        do_cmd(8'h62, 1, 1'b1, 1'b0, 1'b0, "R7 stop after one byte");
        do_cmd(8'h62, 0, 1'b0, 1'b0, 1'b0, "R7 start before bytes");
        do_cmd(8'h62, 1, 1'b0, 1'b0, 1'b0, "R7 start after one byte");
        do_cmd(8'h62, 2, 1'b1, 1'b0, 1'b0, "R6 set rev");
        read_flags("after set rev");
        do_cmd(8'h63, 0, 1'b1, 1'b1, 1'b1, "R5 read rev WP high");

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(prot_lower == 1'b1, "R8 reset keeps flag", prot_lower, 1);
        rst_n = 1'b1;
        @(negedge clk);
        read_flags("R8 after reset");

        do_cmd(8'h66, 4, 1'b1, 1'b0, 1'b0, "R10 clear rev extra bytes");
        read_flags("after clear rev");
        a0_hv = 1'b0;
        do_cmd(8'h62, 2, 1'b1, 1'b0, 1'b0, "R2 rev code without hv");

        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            a = {4'b0110, 4'($urandom_range(0, 15))};
            if ($urandom_range(0, 9) == 0) a = 8'($urandom);
            strap = 3'($urandom_range(0, 7));
            a0_hv = 1'($urandom_range(0, 1));
            if (classify(a, strap, a0_hv) == 1) a[0] = 1'b1;
            do_cmd(a, $urandom_range(0, 3), $urandom_range(0, 3) != 0,
                   $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, "random");
        end

        strap = 3'b010;
        a0_hv = 1'b1;
        do_cmd(8'h66, 2, 1'b1, 1'b0, 1'b0, "R6 clear rev before lock");
        a0_hv = 1'b0;
        do_cmd(8'h64, 2, 1'b1, 1'b0, 1'b0, "R4 R2 set perm");
        check(m_perm == 1'b1, "R4 model lock", m_perm, 1);
        do_cmd(8'h65, 0, 1'b1, 1'b0, 1'b0, "R4 read perm locked");
        do_cmd(8'h64, 2, 1'b1, 1'b0, 1'b0, "R4 set perm again");
        a0_hv = 1'b1;
        do_cmd(8'h62, 2, 1'b1, 1'b0, 1'b0, "R4 set rev locked");
        do_cmd(8'h66, 2, 1'b1, 1'b0, 1'b0, "R4 clear rev locked");
        do_cmd(8'h63, 0, 1'b1, 1'b0, 1'b0, "R4 read rev locked");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(prot_lower == 1'b1, "R4 R8 lock survives reset", prot_lower, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule